// File: doc/BRIEF.md
# Line Miss Buffer with Load Merging

This block keeps track of cache lines that a load pipeline has missed on and is waiting to receive from the next cache level. A missing load whose line is not yet tracked claims a free entry. In the same cycle the block sends one line request downstream, tagged with the entry number. Each entry holds one 64-byte line. A later missing load that falls anywhere in a line already being tracked joins that entry. It does not start a second request, so each line costs exactly one downstream request no matter how many loads wait on it.

The next level answers with the entry number and the whole line. The entry stores the line. It then hands each waiting load its own 8-byte word, one response per cycle, in a fixed order. A load is identified by a small tag. When no entry is free, or when the entry a load would join already holds its maximum number of waiters, the load is refused with a retry. The load pipeline is expected to present it again later. The block never loses a load.

Addresses arrive as word addresses: byte address bits 31:3. Bits 28:3 of the port are the line number (byte address bits 31:6). Bits 2:0 pick the 8-byte word within the line (byte address bits 5:3). Load tags must be unique among loads still waiting.

Top module: `miss_merge_buffer`

## Requirements
- R1: After reset no entry is live: `buf_full` is 0, `ld_resp_valid` is 0, and `dn_req_valid` is 0 while no miss is presented.
- R2: A miss whose line matches no live entry, presented while an entry is free, raises `dn_req_valid` in the same cycle. `dn_req_line` equals the load's line number, `dn_req_idx` is the lowest-numbered free entry, and `ld_miss_retry` stays 0.
- R3: A miss whose line number equals that of a live entry joins that entry. It raises neither `dn_req_valid` nor `ld_miss_retry`, and the word-select bits play no part in the match.
- R4: An entry holds at most 4 waiting loads. A matching miss on an entry that already has 4 waiting is refused with `ld_miss_retry` and is not recorded.
- R5: `buf_full` is 1 exactly when all 4 entries are live. A miss matching no entry is then refused with `ld_miss_retry`, issues no request and is not recorded.
- R6: `dn_fill_valid` with the index of an entry waiting for its line stores the 512-bit line. Word w is bits 64w+63 down to 64w. If no other entry is answering, the first response is on the ports in the second cycle after the cycle in which the fill was presented.
- R7: At most one response goes out per cycle. Among entries holding a line, the lowest index is served first, and within an entry the lowest tag is served first. `ld_resp_data` is the word that the load's word-select bits name.
- R8: An entry becomes free for allocation, and `buf_full` drops, in the same cycle that its last waiting load's response is on the ports.
- R9: A miss presented in the same cycle as the fill for its line joins the entry and is answered from the filled line. No new request goes out.
- R10: A fill naming an entry that is not waiting for a line is ignored. It produces no response and leaves that entry free.
- R11: A miss to a line whose entry already holds data and is still answering joins that entry and is answered from the stored line, without a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_miss_valid | input | 1 | A missing load is presented |
| ld_miss_wad | input | 29 | Word address of the load (byte address bits 31:3) |
| ld_miss_tag | input | 3 | Tag identifying the load |
| ld_miss_retry | output | 1 | The presented load was refused and must be presented again |
| buf_full | output | 1 | All entries are live |
| dn_req_valid | output | 1 | A line request goes to the next level this cycle |
| dn_req_line | output | 26 | Line number requested |
| dn_req_idx | output | 2 | Entry that will receive the line |
| dn_fill_valid | input | 1 | The next level returns a line |
| dn_fill_idx | input | 2 | Entry the returned line belongs to |
| dn_fill_data | input | 512 | Returned line, word w in bits 64w+63:64w |
| ld_resp_valid | output | 1 | A response to a waiting load |
| ld_resp_tag | output | 3 | Tag of the answered load |
| ld_resp_data | output | 64 | The 8-byte word requested by that load |

## Verification
Corrupted entry state reaches the ports within a few cycles. A wrongly set or cleared waiter bit either produces a response to a tag that never asked or leaves a load unanswered. Both differ from the reference on the first cycle the drain order reaches that entry. A stale live or free flag shifts `buf_full`, `dn_req_idx` or `ld_miss_retry` on the very next miss. A broken line match shows up as a second request for a pending line in the cycle the load is presented. The bench's cycle-accurate model flags any of these at the first sampled cycle where the ports disagree.

// File: rtl/mmb_pkg.sv
package mmb_pkg;

    typedef enum logic [1:0] {
        ENT_IDLE  = 2'd0,
        ENT_WAIT  = 2'd1,
        ENT_DRAIN = 2'd2
    } ent_state_t;

endpackage

// File: rtl/mmb_first_set.sv
module mmb_first_set #(
    parameter int W = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mmb_match.sv
module mmb_match #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 26
) (
    input  logic [ENTRIES-1:0] live,
    input  logic [LINE_W-1:0]  lines [ENTRIES],
    input  logic [LINE_W-1:0]  probe,
    output logic [ENTRIES-1:0] hit
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit[g] = live[g] && (lines[g] == probe);
    end
endmodule

// File: rtl/miss_merge_buffer.sv
module miss_merge_buffer
    import mmb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 8,
    parameter int ENTRIES    = 4,
    parameter int TAGS       = 8,
    parameter int MAX_MERGE  = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int WORD_LSB  = $clog2(WORD_BYTES),
    localparam int WSEL_W    = OFF_W - WORD_LSB,
    localparam int WAD_W     = ADDR_W - WORD_LSB,
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int WORD_BITS = WORD_BYTES * 8,
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int TAG_W     = (TAGS > 1) ? $clog2(TAGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_miss_valid,
    input  logic [WAD_W-1:0]     ld_miss_wad,
    input  logic [TAG_W-1:0]     ld_miss_tag,
    output logic                 ld_miss_retry,
    output logic                 buf_full,
    output logic                 dn_req_valid,
    output logic [LINE_W-1:0]    dn_req_line,
    output logic [IDX_W-1:0]     dn_req_idx,
    input  logic                 dn_fill_valid,
    input  logic [IDX_W-1:0]     dn_fill_idx,
    input  logic [LINE_BITS-1:0] dn_fill_data,
    output logic                 ld_resp_valid,
    output logic [TAG_W-1:0]     ld_resp_tag,
    output logic [WORD_BITS-1:0] ld_resp_data
);

    typedef struct packed {
        ent_state_t           st;
        logic [LINE_W-1:0]    line;
        logic [TAGS-1:0]      waiters;
        logic [LINE_BITS-1:0] data;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0]             ent;
        logic [TAGS-1:0][WSEL_W-1:0]    wsel;
        logic                           resp_v;
        logic [TAG_W-1:0]               resp_tag;
        logic [WORD_BITS-1:0]           resp_data;
    } state_t;

    state_t s_q, s_d;

    logic [ENTRIES-1:0] live_w, free_w, drain_w, hit_w;
    logic [LINE_W-1:0]  line_arr [ENTRIES];
    logic [LINE_W-1:0]  miss_line;
    logic [WSEL_W-1:0]  miss_wsel;
    logic               hit_any, free_any, rd_any, tag_any;
    logic [IDX_W-1:0]   hit_idx, free_idx, rd_idx;
    logic [TAG_W-1:0]   rd_tag;
    logic [TAGS-1:0]    rd_waiters;
    logic               merge_room, acc_merge, acc_alloc, resp_fire;
    logic [WORD_BITS-1:0] rd_word;

    assign miss_line = ld_miss_wad[WAD_W-1:WSEL_W];
    assign miss_wsel = ld_miss_wad[WSEL_W-1:0];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign live_w[g]   = (s_q.ent[g].st != ENT_IDLE);
        assign free_w[g]   = (s_q.ent[g].st == ENT_IDLE);
        assign drain_w[g]  = (s_q.ent[g].st == ENT_DRAIN) && (|s_q.ent[g].waiters);
        assign line_arr[g] = s_q.ent[g].line;
    end

    mmb_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_match (
        .live (live_w),
        .lines(line_arr),
        .probe(miss_line),
        .hit  (hit_w)
    );

    mmb_first_set #(.W(ENTRIES)) u_hit_pick (
        .vec(hit_w), .found(hit_any), .idx(hit_idx)
    );

    mmb_first_set #(.W(ENTRIES)) u_free_pick (
        .vec(free_w), .found(free_any), .idx(free_idx)
    );

    mmb_first_set #(.W(ENTRIES)) u_drain_pick (
        .vec(drain_w), .found(rd_any), .idx(rd_idx)
    );

    assign rd_waiters = s_q.ent[rd_idx].waiters;

    mmb_first_set #(.W(TAGS)) u_tag_pick (
        .vec(rd_waiters), .found(tag_any), .idx(rd_tag)
    );

    assign resp_fire  = rd_any && tag_any;
    assign rd_word    = s_q.ent[rd_idx].data[s_q.wsel[rd_tag]*WORD_BITS +: WORD_BITS];
    assign merge_room = ($countones(s_q.ent[hit_idx].waiters) < MAX_MERGE);
    assign acc_merge  = ld_miss_valid && hit_any && merge_room;
    assign acc_alloc  = ld_miss_valid && !hit_any && free_any;

    always_comb begin
        s_d           = s_q;
        s_d.resp_v    = resp_fire;
        s_d.resp_tag  = rd_tag;
        s_d.resp_data = rd_word;
        if (resp_fire) begin
            s_d.ent[rd_idx].waiters[rd_tag] = 1'b0;
        end
        if (acc_merge) begin
            s_d.ent[hit_idx].waiters[ld_miss_tag] = 1'b1;
            s_d.wsel[ld_miss_tag]                 = miss_wsel;
        end
        if (acc_alloc) begin
            s_d.ent[free_idx].st      = ENT_WAIT;
            s_d.ent[free_idx].line    = miss_line;
            s_d.ent[free_idx].waiters = TAGS'(1) << ld_miss_tag;
            s_d.wsel[ld_miss_tag]     = miss_wsel;
        end
        if (dn_fill_valid && (s_q.ent[dn_fill_idx].st == ENT_WAIT)) begin
            s_d.ent[dn_fill_idx].st   = ENT_DRAIN;
            s_d.ent[dn_fill_idx].data = dn_fill_data;
        end
        for (int e = 0; e < ENTRIES; e++) begin
            if ((s_d.ent[e].st == ENT_DRAIN) && (s_d.ent[e].waiters == '0)) begin
                s_d.ent[e].st = ENT_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ld_miss_retry = ld_miss_valid && !acc_merge && !acc_alloc;
    assign buf_full      = !free_any;
    assign dn_req_valid  = acc_alloc;
    assign dn_req_line   = miss_line;
    assign dn_req_idx    = free_idx;
    assign ld_resp_valid = s_q.resp_v;
    assign ld_resp_tag   = s_q.resp_tag;
    assign ld_resp_data  = s_q.resp_data;

    // ---------------- assertions ----------------
    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        // R8: an answering entry with nobody left never lingers
        p_no_empty_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !((s_q.ent[g].st == ENT_DRAIN) && (s_q.ent[g].waiters == '0)));
        // R4: waiting entries hold between one and MAX_MERGE loads
        p_waiter_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.ent[g].st == ENT_WAIT) |->
                ((s_q.ent[g].waiters != '0) && ($countones(s_q.ent[g].waiters) <= MAX_MERGE)));
        for (genvar h = g + 1; h < ENTRIES; h++) begin : g_pair
            // R3: a line is never tracked twice
            p_unique_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !(live_w[g] && live_w[h] && (s_q.ent[g].line == s_q.ent[h].line)));
        end
    end

    // R2: a request always names an entry that then waits for its line
    p_req_claims_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |=> (s_q.ent[$past(dn_req_idx)].st == ENT_WAIT));

    // R6: a fill to a waiting entry moves it to answering
    p_fill_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_fill_valid && (s_q.ent[dn_fill_idx].st == ENT_WAIT)) |=>
            (s_q.ent[$past(dn_fill_idx)].st == ENT_DRAIN));

    // R7: an answered tag is no longer waiting anywhere
    for (genvar g = 0; g < ENTRIES; g++) begin : g_resp_chk
        p_answered_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ld_resp_valid |-> !s_q.ent[g].waiters[ld_resp_tag]);
    end

endmodule

// File: tb/miss_merge_buffer_bench.sv
module miss_merge_buffer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic         rst_n;
    logic         ld_miss_valid;
    logic [28:0]  ld_miss_wad;
    logic [2:0]   ld_miss_tag;
    logic         ld_miss_retry;
    logic         buf_full;
    logic         dn_req_valid;
    logic [25:0]  dn_req_line;
    logic [1:0]   dn_req_idx;
    logic         dn_fill_valid;
    logic [1:0]   dn_fill_idx;
    logic [511:0] dn_fill_data;
    logic         ld_resp_valid;
    logic [2:0]   ld_resp_tag;
    logic [63:0]  ld_resp_data;

    miss_merge_buffer u_miss_merge_buffer (
        .clk(clk), .rst_n(rst_n),
        .ld_miss_valid(ld_miss_valid), .ld_miss_wad(ld_miss_wad), .ld_miss_tag(ld_miss_tag),
        .ld_miss_retry(ld_miss_retry), .buf_full(buf_full),
        .dn_req_valid(dn_req_valid), .dn_req_line(dn_req_line), .dn_req_idx(dn_req_idx),
        .dn_fill_valid(dn_fill_valid), .dn_fill_idx(dn_fill_idx), .dn_fill_data(dn_fill_data),
        .ld_resp_valid(ld_resp_valid), .ld_resp_tag(ld_resp_tag), .ld_resp_data(ld_resp_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [511:0] mk_line(logic [25:0] ln);
        logic [511:0] d;
        for (int w = 0; w < 8; w++) d[64*w +: 64] = {6'b0, ln, 32'hC0DE_0000 | 32'(w)};
        return d;
    endfunction

    // ---------------- reference model ----------------
    bit           m_busy [NE];
    bit           m_fill [NE];
    logic [25:0]  m_line [NE];
    logic [511:0] m_data [NE];
    bit   [7:0]   m_wait [NE];
    logic [2:0]   m_wsel [8];
    bit           m_rv;
    logic [2:0]   m_rt;
    logic [63:0]  m_rd;

    always @(negedge clk) begin : model
        int hit, fr, pe, pt, cnt;
        bit em, ea, er;
        if (!rst_n) begin
            for (int e = 0; e < NE; e++) begin
                m_busy[e] = 0; m_fill[e] = 0; m_wait[e] = '0;
            end
            m_rv = 0;
        end else if (!done) begin
            hit = -1; fr = -1;
            for (int e = NE - 1; e >= 0; e--) begin
                if (m_busy[e] && m_line[e] == ld_miss_wad[28:3]) hit = e;
                if (!m_busy[e]) fr = e;
            end
            cnt = (hit >= 0) ? $countones(m_wait[hit]) : 0;
            em = ld_miss_valid && hit >= 0 && cnt < 4;
            ea = ld_miss_valid && hit < 0 && fr >= 0;
            er = ld_miss_valid && !em && !ea;
            check("R4/R5", "model retry", 64'(ld_miss_retry), 64'(er));
            check("R2", "model req valid", 64'(dn_req_valid), 64'(ea));
            if (ea) begin
                check("R2", "model req idx", 64'(dn_req_idx), 64'(fr));
                check("R2", "model req line", 64'(dn_req_line), 64'(ld_miss_wad[28:3]));
            end
            check("R5", "model full", 64'(buf_full), 64'(fr < 0));
            check("R7", "model resp valid", 64'(ld_resp_valid), 64'(m_rv));
            if (m_rv) begin
                check("R7", "model resp tag", 64'(ld_resp_tag), 64'(m_rt));
                check("R7", "model resp data", ld_resp_data, m_rd);
            end
            // advance one clock
            pe = -1; pt = -1;
            for (int e = NE - 1; e >= 0; e--)
                if (m_busy[e] && m_fill[e] && m_wait[e] != 0) pe = e;
            if (pe >= 0) begin
                for (int t = 7; t >= 0; t--) if (m_wait[pe][t]) pt = t;
                m_rv = 1; m_rt = 3'(pt);
                m_rd = m_data[pe][64*m_wsel[pt] +: 64];
                m_wait[pe][pt] = 0;
            end else m_rv = 0;
            if (em) begin
                m_wait[hit][ld_miss_tag] = 1; m_wsel[ld_miss_tag] = ld_miss_wad[2:0];
            end
            if (ea) begin
                m_busy[fr] = 1; m_fill[fr] = 0; m_line[fr] = ld_miss_wad[28:3];
                m_wait[fr] = '0; m_wait[fr][ld_miss_tag] = 1; m_wsel[ld_miss_tag] = ld_miss_wad[2:0];
            end
            if (dn_fill_valid && m_busy[dn_fill_idx] && !m_fill[dn_fill_idx]) begin
                m_fill[dn_fill_idx] = 1; m_data[dn_fill_idx] = dn_fill_data;
            end
            for (int e = 0; e < NE; e++)
                if (m_busy[e] && m_fill[e] && m_wait[e] == 0) m_busy[e] = 0;
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(bit mv, logic [25:0] ln, logic [2:0] w, logic [2:0] t,
                        bit fv, logic [1:0] fi, logic [25:0] fln);
        @(posedge clk);
        #2;
        ld_miss_valid = mv;
        ld_miss_wad   = {ln, w};
        ld_miss_tag   = t;
        dn_fill_valid = fv;
        dn_fill_idx   = fi;
        dn_fill_data  = mk_line(fln);
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 26'h0, 3'd0, 3'd0, 0, 2'd0, 26'h0);
    endtask

    localparam logic [25:0] LA = 26'h0040001;
    localparam logic [25:0] LB = 26'h0040002;
    localparam logic [25:0] LC = 26'h0040003;
    localparam logic [25:0] LD = 26'h0040004;
    localparam logic [25:0] LE = 26'h0040005;
    localparam logic [25:0] LF = 26'h0040006;

    initial begin
        rst_n = 0; ld_miss_valid = 0; ld_miss_wad = '0; ld_miss_tag = '0;
        dn_fill_valid = 0; dn_fill_idx = '0; dn_fill_data = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        check("R1", "full after reset", 64'(buf_full), 0);
        check("R1", "resp after reset", 64'(ld_resp_valid), 0);
        check("R1", "req after reset", 64'(dn_req_valid), 0);

        // merging into one entry
        step(1, LA, 3'd1, 3'd0, 0, 0, 0);
        check("R2", "alloc req", 64'(dn_req_valid), 1);
        check("R2", "alloc line", 64'(dn_req_line), 64'(LA));
        check("R2", "alloc idx", 64'(dn_req_idx), 0);
        step(1, LA, 3'd6, 3'd1, 0, 0, 0);
        check("R3", "merge no req", 64'(dn_req_valid), 0);
        check("R3", "merge no retry", 64'(ld_miss_retry), 0);
        step(1, LA, 3'd2, 3'd2, 0, 0, 0);
        step(1, LA, 3'd0, 3'd3, 0, 0, 0);
        step(1, LA, 3'd5, 3'd4, 0, 0, 0);
        check("R4", "fifth merge retried", 64'(ld_miss_retry), 1);
        check("R4", "fifth merge no req", 64'(dn_req_valid), 0);
        step(0, 0, 0, 0, 1, 2'd0, LA);
        idle();
        check("R6", "no resp yet", 64'(ld_resp_valid), 0);
        idle();
        check("R6", "first resp", 64'(ld_resp_valid), 1);
        check("R6", "first tag", 64'(ld_resp_tag), 0);
        check("R6", "first word", ld_resp_data, mk_line(LA)[64*1 +: 64]);
        idle();
        check("R7", "second tag", 64'(ld_resp_tag), 1);
        idle();
        check("R7", "third tag", 64'(ld_resp_tag), 2);
        idle();
        check("R7", "fourth tag", 64'(ld_resp_tag), 3);
        idle();
        check("R4", "retried load not recorded", 64'(ld_resp_valid), 0);

        // filling the buffer
        step(1, LA, 3'd0, 3'd0, 0, 0, 0);
        step(1, LB, 3'd0, 3'd1, 0, 0, 0);
        step(1, LC, 3'd0, 3'd2, 0, 0, 0);
        step(1, LD, 3'd0, 3'd3, 0, 0, 0);
        step(1, LE, 3'd0, 3'd4, 0, 0, 0);
        check("R5", "full", 64'(buf_full), 1);
        check("R5", "new line retried", 64'(ld_miss_retry), 1);
        check("R5", "no req when full", 64'(dn_req_valid), 0);
        step(1, LB, 3'd7, 3'd5, 0, 0, 0);
        check("R3", "merge while full", 64'(ld_miss_retry), 0);
        step(0, 0, 0, 0, 1, 2'd3, LD);
        idle();
        check("R8", "still full", 64'(buf_full), 1);
        idle();
        check("R8", "last resp", 64'(ld_resp_tag), 3);
        check("R8", "freed with last resp", 64'(buf_full), 0);
        step(1, LE, 3'd0, 3'd4, 0, 0, 0);
        check("R2", "reuse freed idx", 64'(dn_req_idx), 3);
        step(0, 0, 0, 0, 1, 2'd1, LB);
        step(0, 0, 0, 0, 1, 2'd0, LA);
        idle();
        check("R7", "entry1 first", 64'(ld_resp_tag), 1);
        idle();
        check("R7", "entry0 preempts", 64'(ld_resp_tag), 0);
        idle();
        check("R7", "entry1 rest", 64'(ld_resp_tag), 5);
        check("R7", "rest word", ld_resp_data, mk_line(LB)[64*7 +: 64]);

        // fill to a free entry
        step(0, 0, 0, 0, 1, 2'd0, LA);
        for (int i = 0; i < 3; i++) begin
            idle();
            check("R10", "ignored fill no resp", 64'(ld_resp_valid), 0);
        end
        step(1, LF, 3'd0, 3'd0, 0, 0, 0);
        check("R10", "entry0 still free", 64'(dn_req_idx), 0);

        // miss together with its fill
        step(1, LC, 3'd4, 3'd7, 1, 2'd2, LC);
        check("R9", "same-cycle no req", 64'(dn_req_valid), 0);
        check("R9", "same-cycle no retry", 64'(ld_miss_retry), 0);
        idle();
        idle();
        check("R9", "fill resp", 64'(ld_resp_tag), 2);
        idle();
        check("R9", "joined resp", 64'(ld_resp_tag), 7);
        check("R9", "joined word", ld_resp_data, mk_line(LC)[64*4 +: 64]);

        // join while answering
        step(1, LE, 3'd3, 3'd1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 2'd3, LE);
        idle();
        step(1, LE, 3'd7, 3'd2, 0, 0, 0);
        check("R11", "join draining no req", 64'(dn_req_valid), 0);
        check("R11", "join draining no retry", 64'(ld_miss_retry), 0);
        check("R11", "drain first", 64'(ld_resp_tag), 1);
        idle();
        check("R11", "drain second", 64'(ld_resp_tag), 4);
        idle();
        check("R11", "late joiner", 64'(ld_resp_tag), 2);
        check("R11", "late word", ld_resp_data, mk_line(LE)[64*7 +: 64]);
        step(0, 0, 0, 0, 1, 2'd0, LF);
        repeat (8) idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule